// File: doc/BRIEF.md
# Access/Execute Data Queue Fabric

This block connects an address-generating access core to an arithmetic execute core. It holds three first-in first-out queues. The load queue carries operands from the access side to the execute side. The store-data queue carries results from the execute side. The store-address queue carries destinations from the access side. The cores run apart from each other, and the queues absorb the distance between them. When a queue is empty, its consumer stalls, so each queue is also a point of synchronisation.

Each load entry carries one tag bit. With that bit, the access side can push an end-of-data marker in place of an operand when it finishes a loop. The execute side sees the marker at the head of the load queue and leaves the loop. The block also joins the heads of the two store queues into one cache write request. A request exists only while both heads are present, and it is consumed with a single handshake.

Every data port uses valid/ready. A push is taken on a cycle where valid and ready are both high. Ready falls when the queue is full. A pop is taken when the queue's valid and the consumer's ready are both high. The store request waits on `st_req_ready` and holds both store queues while that input is low.

Top module: `dqi_queue_fabric`

## Requirements
- R1: Load values leave in the order they were pushed. An entry pushed at a clock edge appears at `ld_pop_valid`/`ld_pop_data` after that edge.
- R2: While the load queue is empty, `ld_empty` is 1 and `ld_pop_valid` is 0. Asserting `ld_pop_ready` while the queue is empty changes nothing.
- R3: A load push with `ld_push_eod`=1 enqueues an end-of-data marker. When the marker reaches the head, `ld_pop_eod` is 1 and `ld_pop_data` reads all zeros, whatever data was pushed with it.
- R4: End-of-data markers keep their position among ordinary load values, and a marker is removed by a normal pop.
- R5: `st_req_valid` is 1 exactly when both the store-data and store-address queues are non-empty.
- R6: Store requests pair the Nth pushed address with the Nth pushed data value, in push order. This holds whichever side arrives first.
- R7: While `st_req_valid`=1 and `st_req_ready`=0, neither store queue is popped, and `st_req_addr`/`st_req_data` stay unchanged.
- R8: A queue that holds DEPTH entries (default 16) shows its full flag and drops its push ready. A push offered while the queue is full is discarded and does not disturb the stored entries.
- R9: After reset, all three queues are empty, no full flag is set, and `ld_pop_valid` and `st_req_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_push_valid | input | 1 | Access side offers a load entry |
| ld_push_ready | output | 1 | Load queue can accept |
| ld_push_data | input | DATA_W | Load operand |
| ld_push_eod | input | 1 | Entry is an end-of-data marker |
| ld_pop_valid | output | 1 | Load head available |
| ld_pop_ready | input | 1 | Execute side takes the head |
| ld_pop_data | output | DATA_W | Head operand (zero for a marker) |
| ld_pop_eod | output | 1 | Head is end-of-data (loop exit) |
| sd_push_valid | input | 1 | Execute side offers store data |
| sd_push_ready | output | 1 | Store-data queue can accept |
| sd_push_data | input | DATA_W | Store value |
| sa_push_valid | input | 1 | Access side offers store address |
| sa_push_ready | output | 1 | Store-address queue can accept |
| sa_push_addr | input | ADDR_W | Store address |
| st_req_valid | output | 1 | Paired store request available |
| st_req_ready | input | 1 | Cache accepts the request |
| st_req_addr | output | ADDR_W | Request address |
| st_req_data | output | DATA_W | Request data |
| ld_full | output | 1 | Load queue full |
| ld_empty | output | 1 | Load queue empty |
| sd_full | output | 1 | Store-data queue full |
| sd_empty | output | 1 | Store-data queue empty |
| sa_full | output | 1 | Store-address queue full |
| sa_empty | output | 1 | Store-address queue empty |

## Verification
The hardest case to reach is a full store-address queue with a refused extra push, followed by the check that this refused entry never shows up in any request. Only a drain of all queued pairs can show this. The stimulus first fills the address queue while no data is present, so no request can drain it. It then offers one more address with a distinct value, supplies sixteen data values, and drains all sixteen pairs while checking each one. Back-pressure is covered by holding `st_req_ready` low for several cycles while both heads are present.

// File: rtl/dqi_pkg.sv
package dqi_pkg;
  parameter int DQI_DATA_W = 32;
  parameter int DQI_ADDR_W = 32;
  parameter int DQI_DEPTH  = 16;

  typedef enum logic {
    LD_KIND_VALUE = 1'b0,
    LD_KIND_EOD   = 1'b1
  } ld_kind_e;
endpackage

// File: rtl/dqi_fifo.sv
module dqi_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          push, pop;

  assign full      = (cnt == CNT_MAX);
  assign empty     = (cnt == '0);
  assign in_ready  = !full;
  assign out_valid = !empty;
  assign out_data  = mem[rd_ptr];
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R8: a refused push leaves the occupancy unchanged
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && full && !out_ready) |=> full);

  // R1: the head holds while nobody takes it
  a_r1_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/dqi_load_tag.sv
module dqi_load_tag
  import dqi_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] push_data,
  input  logic          push_eod,
  output logic [DW:0]   entry_in,
  input  logic [DW:0]   entry_out,
  input  logic          head_valid,
  output logic [DW-1:0] pop_data,
  output logic          pop_eod
);
  ld_kind_e kind_in, kind_out;

  assign kind_in  = push_eod ? LD_KIND_EOD : LD_KIND_VALUE;
  assign entry_in = {kind_in, push_data};
  assign kind_out = ld_kind_e'(entry_out[DW]);
  assign pop_eod  = head_valid && (kind_out == LD_KIND_EOD);
  assign pop_data = (kind_out == LD_KIND_EOD) ? '0 : entry_out[DW-1:0];
endmodule

// File: rtl/dqi_store_join.sv
module dqi_store_join #(
  parameter int DW = 32,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_valid,
  output logic          a_ready,
  input  logic [AW-1:0] a_addr,
  input  logic          d_valid,
  output logic          d_ready,
  input  logic [DW-1:0] d_data,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_data
);
  logic fire;

  assign req_valid = a_valid && d_valid;
  assign fire      = req_valid && req_ready;
  assign a_ready   = fire;
  assign d_ready   = fire;
  assign req_addr  = a_addr;
  assign req_data  = d_data;

  // R7: a stalled request holds its content
  a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_data)));
endmodule

// File: rtl/dqi_queue_fabric.sv
module dqi_queue_fabric
  import dqi_pkg::*;
#(
  parameter int DATA_W = DQI_DATA_W,
  parameter int ADDR_W = DQI_ADDR_W,
  parameter int DEPTH  = DQI_DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_push_valid,
  output logic              ld_push_ready,
  input  logic [DATA_W-1:0] ld_push_data,
  input  logic              ld_push_eod,
  output logic              ld_pop_valid,
  input  logic              ld_pop_ready,
  output logic [DATA_W-1:0] ld_pop_data,
  output logic              ld_pop_eod,
  input  logic              sd_push_valid,
  output logic              sd_push_ready,
  input  logic [DATA_W-1:0] sd_push_data,
  input  logic              sa_push_valid,
  output logic              sa_push_ready,
  input  logic [ADDR_W-1:0] sa_push_addr,
  output logic              st_req_valid,
  input  logic              st_req_ready,
  output logic [ADDR_W-1:0] st_req_addr,
  output logic [DATA_W-1:0] st_req_data,
  output logic              ld_full,
  output logic              ld_empty,
  output logic              sd_full,
  output logic              sd_empty,
  output logic              sa_full,
  output logic              sa_empty
);
  localparam int LW = DATA_W + 1;

  logic [LW-1:0]     ld_entry_in, ld_entry_out;
  logic              sd_head_valid, sd_head_pop;
  logic              sa_head_valid, sa_head_pop;
  logic [DATA_W-1:0] sd_head_data;
  logic [ADDR_W-1:0] sa_head_addr;

  dqi_load_tag #(.DW(DATA_W)) u_tag (
    .push_data (ld_push_data),
    .push_eod  (ld_push_eod),
    .entry_in  (ld_entry_in),
    .entry_out (ld_entry_out),
    .head_valid(ld_pop_valid),
    .pop_data  (ld_pop_data),
    .pop_eod   (ld_pop_eod)
  );

  dqi_fifo #(.W(LW), .DEPTH(DEPTH)) u_ldq (
    .clk(clk), .rst_n(rst_n),
    .in_valid(ld_push_valid), .in_ready(ld_push_ready), .in_data(ld_entry_in),
    .out_valid(ld_pop_valid), .out_ready(ld_pop_ready), .out_data(ld_entry_out),
    .full(ld_full), .empty(ld_empty)
  );

  dqi_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_sdq (
    .clk(clk), .rst_n(rst_n),
    .in_valid(sd_push_valid), .in_ready(sd_push_ready), .in_data(sd_push_data),
    .out_valid(sd_head_valid), .out_ready(sd_head_pop), .out_data(sd_head_data),
    .full(sd_full), .empty(sd_empty)
  );

  dqi_fifo #(.W(ADDR_W), .DEPTH(DEPTH)) u_saq (
    .clk(clk), .rst_n(rst_n),
    .in_valid(sa_push_valid), .in_ready(sa_push_ready), .in_data(sa_push_addr),
    .out_valid(sa_head_valid), .out_ready(sa_head_pop), .out_data(sa_head_addr),
    .full(sa_full), .empty(sa_empty)
  );

  dqi_store_join #(.DW(DATA_W), .AW(ADDR_W)) u_join (
    .clk(clk), .rst_n(rst_n),
    .a_valid(sa_head_valid), .a_ready(sa_head_pop), .a_addr(sa_head_addr),
    .d_valid(sd_head_valid), .d_ready(sd_head_pop), .d_data(sd_head_data),
    .req_valid(st_req_valid), .req_ready(st_req_ready),
    .req_addr(st_req_addr), .req_data(st_req_data)
  );

  // R5: a request never appears while either store queue is empty
  a_r5_pair_present: assert property (@(posedge clk) disable iff (!rst_n)
    st_req_valid |-> (!sd_empty && !sa_empty));

  // R2: an empty load queue offers nothing to the execute side
  a_r2_empty_stall: assert property (@(posedge clk) disable iff (!rst_n)
    ld_empty |-> !ld_pop_valid);

  // R7: a stalled request keeps both store queues from draining
  a_r7_no_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (st_req_valid && !st_req_ready) |=> (!sd_empty && !sa_empty));
endmodule

// File: tb/dqi_queue_fabric_tb.sv
`timescale 1ns/1ps
module dqi_queue_fabric_tb_top;
  localparam int DW = 32;
  localparam int AW = 32;
  localparam int DEPTH = 16;
  localparam int NVEC = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic ld_push_valid, ld_push_eod, ld_pop_ready;
  logic [DW-1:0] ld_push_data;
  logic ld_push_ready, ld_pop_valid, ld_pop_eod;
  logic [DW-1:0] ld_pop_data;
  logic sd_push_valid, sd_push_ready, sa_push_valid, sa_push_ready;
  logic [DW-1:0] sd_push_data, st_req_data;
  logic [AW-1:0] sa_push_addr, st_req_addr;
  logic st_req_valid, st_req_ready;
  logic ld_full, ld_empty, sd_full, sd_empty, sa_full, sa_empty;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dqi_queue_fabric #(.DATA_W(DW), .ADDR_W(AW), .DEPTH(DEPTH)) dut_i (.*);

  // vector: push_v, push_eod, push_data, pop_r, exp_valid, exp_eod, exp_data
  localparam logic [68:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 32'h11, 1'b0, 1'b0, 1'b0, 32'h0},
    {1'b1, 1'b0, 32'h22, 1'b0, 1'b1, 1'b0, 32'h11},
    {1'b1, 1'b1, 32'h5555, 1'b1, 1'b1, 1'b0, 32'h11},
    {1'b0, 1'b0, 32'h0, 1'b1, 1'b1, 1'b0, 32'h22},
    {1'b0, 1'b0, 32'h0, 1'b0, 1'b1, 1'b1, 32'h0},
    {1'b1, 1'b0, 32'h33, 1'b1, 1'b1, 1'b1, 32'h0},
    {1'b0, 1'b0, 32'h0, 1'b1, 1'b1, 1'b0, 32'h33},
    {1'b0, 1'b0, 32'h0, 1'b1, 1'b0, 1'b0, 32'h0},
    {1'b1, 1'b0, 32'h44, 1'b0, 1'b0, 1'b0, 32'h0},
    {1'b0, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0, 32'h44}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    ld_push_valid = 0; ld_push_eod = 0; ld_push_data = '0; ld_pop_ready = 0;
    sd_push_valid = 0; sd_push_data = '0; sa_push_valid = 0; sa_push_addr = '0;
    st_req_ready = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    // R9 reset state
    chk("R9 ld_empty", ld_empty, 1);
    chk("R9 sd_empty", sd_empty, 1);
    chk("R9 sa_empty", sa_empty, 1);
    chk("R9 fulls", {ld_full, sd_full, sa_full}, 0);
    chk("R9 valids", {ld_pop_valid, st_req_valid}, 0);

    // table walk on the load path: R1 R2 R3 R4
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      {ld_push_valid, ld_push_eod, ld_push_data, ld_pop_ready} = {VEC[i][68:67], VEC[i][66:35], VEC[i][34]};
      #1;
      chk("R1/R2 ld_pop_valid", ld_pop_valid, VEC[i][33]);
      if (VEC[i][33]) begin
        chk("R3/R4 ld_pop_eod", ld_pop_eod, VEC[i][32]);
        chk("R1/R3 ld_pop_data", ld_pop_data, VEC[i][31:0]);
      end else begin
        chk("R2 ld_empty", ld_empty, 1);
      end
    end
    @(negedge clk);
    idle_inputs();
    ld_pop_ready = 1;
    @(negedge clk);
    ld_pop_ready = 0;
    #1;
    chk("R2 ld drained", ld_empty, 1);

    // R8 load queue full and refused push
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      ld_push_valid = 1; ld_push_data = 32'hA00 + i;
    end
    @(negedge clk);
    ld_push_data = 32'hBAD;
    #1;
    chk("R8 ld_full", ld_full, 1);
    chk("R8 ld_push_ready", ld_push_ready, 0);
    @(negedge clk);
    ld_push_valid = 0; ld_pop_ready = 1;
    for (int i = 0; i < DEPTH; i++) begin
      #1;
      chk("R8 ld content", ld_pop_data, 32'hA00 + i);
      @(negedge clk);
    end
    ld_pop_ready = 0;
    #1;
    chk("R8 refused entry absent", ld_pop_valid, 0);

    // R5 addresses without data
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      sa_push_valid = 1; sa_push_addr = 32'h1000 + 4 * i;
      #1;
      chk("R5 no request without data", st_req_valid, 0);
    end
    @(negedge clk);
    sa_push_valid = 0;
    for (int i = 0; i < 3; i++) begin
      sd_push_valid = 1; sd_push_data = 32'hD0 + i;
      @(negedge clk);
    end
    sd_push_valid = 0;
    // R7 back-pressure hold
    for (int k = 0; k < 3; k++) begin
      #1;
      chk("R7 valid held", st_req_valid, 1);
      chk("R7 addr held", st_req_addr, 32'h1000);
      chk("R7 data held", st_req_data, 32'hD0);
      @(negedge clk);
    end
    st_req_ready = 1;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk("R6 pair addr", st_req_addr, 32'h1000 + 4 * i);
      chk("R6 pair data", st_req_data, 32'hD0 + i);
      @(negedge clk);
    end
    #1;
    chk("R5 empty after drain", {st_req_valid, sd_empty, sa_empty}, 3'b011);

    // R5/R6 data arrives before address
    @(negedge clk);
    sd_push_valid = 1; sd_push_data = 32'hE7;
    @(negedge clk);
    sd_push_valid = 0;
    #1;
    chk("R5 no request without address", st_req_valid, 0);
    @(negedge clk);
    sa_push_valid = 1; sa_push_addr = 32'h2000;
    @(negedge clk);
    sa_push_valid = 0;
    #1;
    chk("R6 late address pair", {st_req_valid, st_req_addr, st_req_data}, {1'b1, 32'h2000, 32'hE7});
    @(negedge clk);
    st_req_ready = 0;

    // R8 store-address queue full, refused push never issued
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      sa_push_valid = 1; sa_push_addr = 32'h3000 + i;
    end
    @(negedge clk);
    sa_push_addr = 32'hBAD0;
    #1;
    chk("R8 sa_full", sa_full, 1);
    chk("R8 sa_push_ready", sa_push_ready, 0);
    @(negedge clk);
    sa_push_valid = 0;
    for (int i = 0; i < DEPTH; i++) begin
      sd_push_valid = 1; sd_push_data = 32'hF00 + i;
      @(negedge clk);
    end
    sd_push_valid = 0;
    st_req_ready = 1;
    for (int i = 0; i < DEPTH; i++) begin
      #1;
      chk("R6/R8 full drain pair", {st_req_valid, st_req_addr, st_req_data}, {1'b1, 32'h3000 + i, 32'hF00 + i});
      @(negedge clk);
    end
    #1;
    chk("R8 refused address absent", {st_req_valid, sa_empty, sd_empty}, 3'b011);
    finish_run();
  end
endmodule